// File: doc/BRIEF.md
# Converter Wake-Up Sequencer

This block controls the digital output path of a stereo audio converter as it leaves power-down. While the active-low power-down input is low, the block holds both channel outputs at two's-complement zero and clears its internal state. After power-down is released, the block counts frame periods. This initialization phase runs until a count that depends on the clocking role is reached, and both outputs stay forced to zero throughout. Once initialization is complete, the already-decimated left and right sample words pass to the outputs with one clock of latency, and a valid flag is raised.

In master role, the block makes its own frame clock by dividing the master clock, and it starts counting at once. In slave role, it synchronizes an external frame clock into the master clock domain. It stays in power-down until the first frame edge of the selected polarity arrives. If that frame clock later stops, a watchdog returns the block to power-down. The full sequence then starts again when frame edges come back. The role and polarity selects are expected to stay fixed while power-down is released.

Top module: `adc_wake_seq`

## Requirements
- R1: While pdn_n is low, left_out, right_out, valid and lrck_out are all 0, and they go to 0 as soon as pdn_n falls, with no clock edge needed.
- R2: While valid is 0, left_out and right_out are 0 whatever sample values are applied.
- R3: In master role (slave=0), valid first reads 1 after clock edge INIT_MASTER*2^DIV_LOG2+1, counting the first rising clk edge after pdn_n rises as edge 1, and reads 0 after the edge before it.
- R4: In master role, lrck_out after clock edge k (counted as in R3) equals 1 exactly when (k mod 2^DIV_LOG2) >= 2^(DIV_LOG2-1). This gives a 50% duty square wave with a period of 2^DIV_LOG2 clocks.
- R5: In slave role (slave=1), with no frame edge on lrck_in, the block stays in power-down for any number of clocks: valid and both outputs remain 0.
- R6: In slave role, the selected frame edge is rising when fall_sel=0 and falling when fall_sel=1, and edges of the other direction have no effect on timing.
- R7: In slave role, the first selected edge starts initialization. After INIT_SLAVE further selected edges, valid reads 0 after the third rising clk edge that follows the last of those edges and reads 1 after the fourth.
- R8: While valid is 1, left_out and right_out equal the left_in and right_in values sampled at the previous rising clk edge.
- R9: In slave role after initialization has started, if no selected frame edge is seen for WDOG clocks, the block returns to power-down and valid drops one clock later. A new start edge followed by INIT_SLAVE counted edges is then needed before valid is 1 again.
- R10: In slave role, lrck_out is held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| pdn_n | input | 1 | Active-low power-down, asynchronous assert |
| slave | input | 1 | 1 = slave role (external frame clock), 0 = master role |
| fall_sel | input | 1 | Slave frame-edge polarity: 0 rising, 1 falling |
| lrck_in | input | 1 | External frame clock (slave role) |
| left_in | input | W | Left decimated sample, two's complement |
| right_in | input | W | Right decimated sample, two's complement |
| lrck_out | output | 1 | Generated frame clock (master role) |
| left_out | output | W | Left output sample |
| right_out | output | W | Right output sample |
| valid | output | 1 | Output data valid |

## Verification
Each result has a fixed latency after its stimulus. A sample reaches the outputs one clock after it is applied. In master role, valid rises on the clock after the last frame tick. In slave role, a frame-clock change takes three clocks to reach the state machine because of the two-flop synchronizer and the edge register, and valid follows one clock later. The watchdog drops valid WDOG+1 clocks after the last acted-on edge. The bench drives every input just after a rising edge, counts rising edges from that point, and samples one time unit after the edge where each result is due. For each timing requirement it checks the cycle before the change as well as the cycle of the change.

// File: rtl/adc_wake_seq.sv
module adc_wake_seq #(
  parameter int W           = 24,
  parameter int DIV_LOG2    = 8,
  parameter int INIT_MASTER = 4129,
  parameter int INIT_SLAVE  = 4132,
  parameter int WDOG        = 1024
) (
  input  logic         clk,
  input  logic         pdn_n,
  input  logic         slave,
  input  logic         fall_sel,
  input  logic         lrck_in,
  input  logic [W-1:0] left_in,
  input  logic [W-1:0] right_in,
  output logic         lrck_out,
  output logic [W-1:0] left_out,
  output logic [W-1:0] right_out,
  output logic         valid
);

  localparam int NMAX = (INIT_MASTER > INIT_SLAVE) ? INIT_MASTER : INIT_SLAVE;
  localparam int CW   = $clog2(NMAX + 1);
  localparam int WW   = $clog2(WDOG + 1);

  typedef enum logic [1:0] {S_PD, S_INIT, S_RUN} st_t;

  st_t                 st;
  logic [DIV_LOG2-1:0] div;
  logic [2:0]          sy;
  logic [2:0]          arm;
  logic [CW-1:0]       cnt;
  logic [WW-1:0]       wd;

  logic          sedge, mtick, tick, wd_hit;
  logic [CW-1:0] last;

  assign sedge    = arm[2] & (fall_sel ? (~sy[1] & sy[2]) : (sy[1] & ~sy[2]));
  assign mtick    = (div == '1);
  assign tick     = slave ? sedge : mtick;
  assign last     = slave ? CW'(INIT_SLAVE - 1) : CW'(INIT_MASTER - 1);
  assign wd_hit   = slave && (st != S_PD) && !sedge && (wd == WW'(WDOG - 1));
  assign lrck_out = !slave & div[DIV_LOG2-1];

  always_ff @(posedge clk or negedge pdn_n) begin
    if (!pdn_n) begin
      st        <= S_PD;
      div       <= '0;
      sy        <= '0;
      arm       <= '0;
      cnt       <= '0;
      wd        <= '0;
      left_out  <= '0;
      right_out <= '0;
      valid     <= 1'b0;
    end else begin
      sy  <= {sy[1:0], lrck_in};
      arm <= {arm[1:0], 1'b1};
      div <= slave ? '0 : div + 1'b1;

      if (wd_hit) begin
        st <= S_PD;
      end else begin
        case (st)
          S_PD: if (!slave || sedge) begin
            st  <= S_INIT;
            cnt <= '0;
          end
          S_INIT: if (tick) begin
            if (cnt == last) st <= S_RUN;
            cnt <= cnt + 1'b1;
          end
          default: ;
        endcase
      end

      if (!slave || st == S_PD || sedge || wd_hit) wd <= '0;
      else                                          wd <= wd + 1'b1;

      left_out  <= (st == S_RUN) ? left_in  : '0;
      right_out <= (st == S_RUN) ? right_in : '0;
      valid     <= (st == S_RUN);
    end
  end

  always @(negedge clk) begin
    if (!pdn_n)
      a_r1_pd_quiet: assert (!valid && left_out == '0 && right_out == '0 && !lrck_out);
  end

  a_r2_zero_unless_valid: assert property (@(posedge clk) disable iff (!pdn_n)
    !valid |-> (left_out == '0 && right_out == '0));

  a_r8_pass_through: assert property (@(posedge clk) disable iff (!pdn_n)
    valid |-> (left_out == $past(left_in) && right_out == $past(right_in)));

  a_r3_valid_after_init: assert property (@(posedge clk) disable iff (!pdn_n)
    $rose(valid) |-> ($past(st) == S_RUN && $past(st, 2) == S_INIT));

  a_r9_watchdog_drop: assert property (@(posedge clk) disable iff (!pdn_n)
    wd_hit |=> (st == S_PD) ##1 !valid);

  a_r10_slave_no_lrck: assert property (@(posedge clk) disable iff (!pdn_n)
    (slave && $past(slave)) |-> !lrck_out);

endmodule

// File: tb/sim_adc_wake_seq.sv
module sim_adc_wake_seq;
  localparam int W  = 8;
  localparam int DL = 3;
  localparam int M  = 1 << DL;
  localparam int NM = 5;
  localparam int NS = 6;
  localparam int WD = 40;
  localparam int HP = 6;

  localparam logic [15:0] VEC [8] = '{16'h0000, 16'h7F80, 16'h80FF, 16'hFF01,
                                      16'h5AA5, 16'h0102, 16'hC33C, 16'h7FFF};

  logic clk = 0, pdn_n = 0, slave = 0, fall_sel = 0, lrck = 0;
  logic [W-1:0] left_in = 8'h11, right_in = 8'h22;
  logic lrck_out, valid;
  logic [W-1:0] left_out, right_out;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  adc_wake_seq #(.W(W), .DIV_LOG2(DL), .INIT_MASTER(NM), .INIT_SLAVE(NS), .WDOG(WD)) u0 (
    .clk(clk), .pdn_n(pdn_n), .slave(slave), .fall_sel(fall_sel), .lrck_in(lrck),
    .left_in(left_in), .right_in(right_in), .lrck_out(lrck_out),
    .left_out(left_out), .right_out(right_out), .valid(valid));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic quiet(input string tag);
    chk({tag, " valid"}, valid, 0);
    chk({tag, " left"}, left_out, 0);
    chk({tag, " right"}, right_out, 0);
  endtask

  task automatic slave_seq(input logic a, input string tag);
    if (lrck == a) begin lrck = !a; tick(HP); end
    lrck = a; left_in = 8'h3C; right_in = 8'hC3;
    tick(HP);
    for (int i = 1; i <= NS; i++) begin
      lrck = !a; tick(HP);
      quiet({tag, " R2 init"});
      lrck = a;
      if (i < NS) tick(HP);
    end
    tick(3);
    chk({tag, " R7 valid early"}, valid, 0);
    tick(1);
    chk({tag, " R7 valid due"}, valid, 1);
    chk({tag, " R8 first word"}, left_out, 8'h3C);
  endtask

  initial begin
    tick(3);
    quiet("R1 reset");
    chk("R1 reset lrck_out", lrck_out, 0);

    pdn_n = 1;
    for (int k = 1; k <= NM * M + 1; k++) begin
      left_in = W'(k); right_in = ~W'(k);
      tick(1);
      chk("R4 lrck_out", lrck_out, ((k % M) >= M / 2) ? 1 : 0);
      if (k <= NM * M) quiet("R2/R3 master init");
      else begin
        chk("R3 master valid due", valid, 1);
        chk("R8 master first", left_out, W'(k));
      end
    end

    for (int v = 0; v < 8; v++) begin
      left_in = VEC[v][15:8]; right_in = VEC[v][7:0];
      tick(1);
      chk("R8 left", left_out, VEC[v][15:8]);
      chk("R8 right", right_out, VEC[v][7:0]);
    end

    #2 pdn_n = 0; #1;
    quiet("R1 async");
    chk("R1 async lrck_out", lrck_out, 0);

    tick(1);
    slave = 1; lrck = 0; fall_sel = 0;
    pdn_n = 1;
    tick(60);
    quiet("R5 no frame clock");
    chk("R10 slave lrck_out", lrck_out, 0);
    slave_seq(1'b1, "rise");
    chk("R10 slave lrck_out run", lrck_out, 0);

    #2 pdn_n = 0; #1;
    tick(1);
    fall_sel = 1; lrck = 1;
    pdn_n = 1;
    tick(10);
    quiet("R6 falling idle");
    slave_seq(1'b0, "R6 fall");

    left_in = 8'hA7; right_in = 8'h7A;
    tick(WD - 1);
    chk("R9 valid before timeout", valid, 1);
    chk("R8 hold", left_out, 8'hA7);
    tick(1);
    quiet("R9 timeout");
    tick(20);
    quiet("R9 stays down");
    slave_seq(1'b0, "R9 restart");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired actual running expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule